// File: doc/BRIEF.md
# Memory Protection Region Checker

This block sits beside a processor's memory access path and decides, for every access, whether it may proceed. Software programs up to eight regions through a small register port. Each region has a base address, a power-of-two size, an enable, four permission bits, an execute-never flag, a mask that removes any of its eight equal subregions, and a set of memory-type attributes. The access side presents an address, a kind (read, write or instruction fetch) and a privilege flag. The block answers combinationally with allow or fault and reports which region matched.

The register port uses a 3-bit selector. Selector 0 holds the global enable in bit 0. Selector 1 picks the region that later base and attribute writes go to. Selector 2 holds that region's base address, and only bits 31:8 are stored. Selector 3 holds that region's attribute word. Selector 4 is a read-only identification word. The attribute word is laid out as follows:
- bit 0: enable.
- bits 5:1: size code k, giving a region of 2^(k+1) bytes. k must be 7 or more, so the smallest region is 256 B; with k = 31 the region is 4 GB.
- bits 15:8: subregion disable mask.
- bit 16: bufferable. Bit 17: cacheable. Bit 18: shareable. Bits 21:19: type extension.
- bits 27:24: permissions. Bit 24 is privileged read, 25 privileged write, 26 unprivileged read, 27 unprivileged write.
- bit 28: execute-never.

Read data appears on `cfg_rdata` one clock after `cfg_sel` is presented. A fault is also registered, and one cycle later it shows as a one-cycle pulse carrying the faulting address, kind and privilege.

Top module: `region_guard`

## Requirements
- R1: After reset the enable word reads 0. Selector 4 reads 0x00000801: bit 0 means present and bits 15:8 give the region count. The base and attribute words of the region chosen through selector 1 read back what was written, with base bits 7:0 forced to zero.
- R2: While the global enable (selector 0, bit 0) is clear, every access is allowed, no fault is raised, and `hit_valid` is 0, whatever the regions hold.
- R3: A region with size code k covers the addresses whose bits above bit k match the base. Base bits below the region size take no part in the match.
- R4: Subregion number (address >> (k-2)) & 7 is removed from the region's match when its bit in the disable mask is set.
- R5: A read needs the read bit for the access's privilege level and a write needs the write bit. A fetch needs the read bit; acc_kind is 0 for read, 1 for write and 2 for fetch.
- R6: A fetch that hits a region whose execute-never bit is set faults at either privilege level. Reads in that region follow the permission bits.
- R7: When enabled regions overlap, the highest-numbered matching region decides, and `hit_region` reports its number.
- R8: With checking on and no region matching, privileged accesses are allowed and unprivileged accesses fault.
- R9: The bufferable, cacheable, shareable and type-extension fields of the deciding region appear on `hit_mattr` as {tex[2:0], s, c, b}. They have no effect on allow or fault.
- R10: A region whose base and attribute words are written as zero no longer matches any address.
- R11: An access with `acc_valid` high that faults produces `flt_pulse` high in the next cycle, with `flt_addr`, `flt_kind` and `flt_priv` holding that access. The pulse drops the cycle after a cycle with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_sel` |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | 1 for a privileged access |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | Valid access refused |
| hit_valid | output | 1 | Some enabled region matched while checking is on |
| hit_region | output | 3 | Number of the deciding region |
| hit_mattr | output | 6 | {tex, s, c, b} of the deciding region |
| hit_xn | output | 1 | Execute-never of the deciding region |
| flt_pulse | output | 1 | Registered fault pulse |
| flt_addr | output | 32 | Captured faulting address |
| flt_kind | output | 2 | Captured faulting kind |
| flt_priv | output | 1 | Captured faulting privilege |

## Verification
The bench writes a base with low bits set inside a 1 KB region. A design that compared base bits below the region size would then miss addresses it should cover. The bench also probes just past the region's top, where an off-by-one mask would wrongly match. It disables a middle subregion and probes it next to an enabled neighbour; taking the subregion index from the wrong address bits would open or close the wrong slice. Overlapping regions with opposite permissions expose a priority encoder that lets the lowest region win. Execute-never fetches at both privilege levels catch a check applied to only one level. A zeroed region, a cleared global enable, and the fault pulse rising and dropping one cycle late catch stale-state and pipeline mistakes.

// File: rtl/rg_pkg.sv
package rg_pkg;

  localparam int ADDR_W   = 32;
  localparam int CODE_W   = 5;
  localparam int MIN_CODE = 7;
  localparam int BASE_LSB = 8;

  // attribute word layout
  localparam int A_EN     = 0;
  localparam int A_CODE   = 1;
  localparam int A_SRD    = 8;
  localparam int A_MATTR  = 16;
  localparam int A_PERM   = 24;
  localparam int A_XN     = 28;

  // register selectors
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_PICK = 3'd1;
  localparam logic [2:0] SEL_BASE = 3'd2;
  localparam logic [2:0] SEL_ATTR = 3'd3;
  localparam logic [2:0] SEL_TYPE = 3'd4;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
    logic [7:0]        srd;
    logic [5:0]        mattr;
    logic [3:0]        perm;
    logic              xn;
  } region_cfg_t;

  function automatic region_cfg_t unpack_attr(input logic [31:0] w);
    region_cfg_t r;
    r.en    = w[A_EN];
    r.code  = w[A_CODE +: CODE_W];
    r.srd   = w[A_SRD +: 8];
    r.mattr = w[A_MATTR +: 6];
    r.perm  = w[A_PERM +: 4];
    r.xn    = w[A_XN];
    return r;
  endfunction

  function automatic logic [31:0] pack_attr(input region_cfg_t r);
    logic [31:0] w;
    w = '0;
    w[A_EN]             = r.en;
    w[A_CODE +: CODE_W] = r.code;
    w[A_SRD +: 8]       = r.srd;
    w[A_MATTR +: 6]     = r.mattr;
    w[A_PERM +: 4]      = r.perm;
    w[A_XN]             = r.xn;
    return w;
  endfunction

endpackage

// File: rtl/rg_regs.sv
module rg_regs
  import rg_pkg::*;
#(
  parameter int NREG  = 8,
  localparam int IDX_W = $clog2(NREG),
  localparam int BW    = ADDR_W - BASE_LSB
)(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [2:0]                    sel,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic                          chk_on,
  output logic [NREG-1:0][BW-1:0]       base_hi,
  output region_cfg_t [NREG-1:0]        rcfg
);

  localparam logic [31:0] TYPE_WORD = 32'h1 | (32'(NREG) << 8);

  logic [IDX_W-1:0] pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_on  <= 1'b0;
      pick    <= '0;
      base_hi <= '0;
      rcfg    <= '0;
    end else if (we) begin
      case (sel)
        SEL_CTRL: chk_on        <= wdata[0];
        SEL_PICK: pick          <= wdata[IDX_W-1:0];
        SEL_BASE: base_hi[pick] <= wdata[ADDR_W-1:BASE_LSB];
        SEL_ATTR: rcfg[pick]    <= unpack_attr(wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        SEL_CTRL: rdata <= {31'b0, chk_on};
        SEL_PICK: rdata <= 32'(pick);
        SEL_BASE: rdata <= {base_hi[pick], {BASE_LSB{1'b0}}};
        SEL_ATTR: rdata <= pack_attr(rcfg[pick]);
        SEL_TYPE: rdata <= TYPE_WORD;
        default:  rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/rg_region_match.sv
module rg_region_match
  import rg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [7:0]        srd,
  output logic              hit
);

  logic [5:0]        shamt;
  logic [5:0]        sub_sh;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] low_mask;
  logic [2:0]        sidx;
  logic              size_ok;
  logic              in_range;

  always_comb begin
    shamt    = {1'b0, code} + 6'd1;
    sub_sh   = shamt - 6'd3;
    // span wraps to zero for the full address space, so low_mask becomes all ones
    span     = {{(ADDR_W-1){1'b0}}, 1'b1} << shamt;
    low_mask = span - {{(ADDR_W-1){1'b0}}, 1'b1};
    sidx     = 3'(addr >> sub_sh);
    size_ok  = (code >= CODE_W'(MIN_CODE));
    in_range = (((addr ^ base) & ~low_mask) == '0);
    hit      = en && size_ok && in_range && !srd[sidx];
  end

endmodule

// File: rtl/rg_decide.sv
module rg_decide
  import rg_pkg::*;
#(
  parameter int NREG  = 8,
  localparam int IDX_W = $clog2(NREG)
)(
  input  logic                     chk_on,
  input  logic [NREG-1:0]          match,
  input  logic [NREG-1:0][3:0]     perm,
  input  logic [NREG-1:0]          xn,
  input  acc_kind_e                kind,
  input  logic                     priv,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx,
  output logic                     allow
);

  logic [3:0] p;
  logic       rd_ok;
  logic       wr_ok;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    // later iterations override: highest-numbered match decides
    for (int i = 0; i < NREG; i++) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    p     = perm[hit_idx];
    rd_ok = priv ? p[0] : p[2];
    wr_ok = priv ? p[1] : p[3];
    if (!chk_on) begin
      allow = 1'b1;
    end else if (!hit) begin
      allow = priv;
    end else begin
      case (kind)
        KIND_READ:  allow = rd_ok;
        KIND_WRITE: allow = wr_ok;
        KIND_FETCH: allow = rd_ok && !xn[hit_idx];
        default:    allow = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/rg_fault_log.sv
module rg_fault_log
  import rg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fault,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  input  logic              priv,
  output logic              pulse,
  output logic [ADDR_W-1:0] f_addr,
  output logic [1:0]        f_kind,
  output logic              f_priv
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      f_addr <= '0;
      f_kind <= '0;
      f_priv <= 1'b0;
    end else begin
      pulse <= fault;
      if (fault) begin
        f_addr <= addr;
        f_kind <= kind;
        f_priv <= priv;
      end
    end
  end

endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int NREG = 8
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic [1:0]  acc_kind,
  input  logic        acc_priv,
  output logic        acc_allow,
  output logic        acc_fault,
  output logic        hit_valid,
  output logic [2:0]  hit_region,
  output logic [5:0]  hit_mattr,
  output logic        hit_xn,
  output logic        flt_pulse,
  output logic [31:0] flt_addr,
  output logic [1:0]  flt_kind,
  output logic        flt_priv
);

  localparam int IDX_W = $clog2(NREG);
  localparam int BW    = ADDR_W - BASE_LSB;

  logic                    chk_on;
  logic [NREG-1:0][BW-1:0] base_hi;
  region_cfg_t [NREG-1:0]  rcfg;
  logic [NREG-1:0]         match;
  logic [NREG-1:0][3:0]    perm;
  logic [NREG-1:0]         xn;
  logic                    any_hit;
  logic [IDX_W-1:0]        hit_idx;
  logic                    allow_c;

  rg_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .chk_on(chk_on), .base_hi(base_hi), .rcfg(rcfg)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_region
    rg_region_match u_match (
      .addr(acc_addr),
      .base({base_hi[g], {BASE_LSB{1'b0}}}),
      .en(rcfg[g].en),
      .code(rcfg[g].code),
      .srd(rcfg[g].srd),
      .hit(match[g])
    );
    assign perm[g] = rcfg[g].perm;
    assign xn[g]   = rcfg[g].xn;
  end

  rg_decide #(.NREG(NREG)) u_decide (
    .chk_on(chk_on), .match(match), .perm(perm), .xn(xn),
    .kind(acc_kind_e'(acc_kind)), .priv(acc_priv),
    .hit(any_hit), .hit_idx(hit_idx), .allow(allow_c)
  );

  assign acc_allow  = allow_c;
  assign acc_fault  = acc_valid && !allow_c;
  assign hit_valid  = chk_on && any_hit;
  assign hit_region = 3'(hit_idx);
  assign hit_mattr  = hit_valid ? rcfg[hit_idx].mattr : 6'd0;
  assign hit_xn     = hit_valid && rcfg[hit_idx].xn;

  rg_fault_log u_flog (
    .clk(clk), .rst(rst), .fault(acc_fault), .addr(acc_addr),
    .kind(acc_kind), .priv(acc_priv),
    .pulse(flt_pulse), .f_addr(flt_addr), .f_kind(flt_kind), .f_priv(flt_priv)
  );

endmodule

// File: rtl/rg_checker.sv
module rg_checker (
  input logic        clk,
  input logic        rst,
  input logic        chk_on,
  input logic        acc_valid,
  input logic [31:0] acc_addr,
  input logic [1:0]  acc_kind,
  input logic        acc_priv,
  input logic        acc_allow,
  input logic        acc_fault,
  input logic        hit_valid,
  input logic        hit_xn,
  input logic        flt_pulse,
  input logic [31:0] flt_addr
);

  // R2
  off_allows_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_on |-> (acc_allow && !acc_fault && !hit_valid));

  // R6
  xn_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && hit_valid && hit_xn && acc_kind == 2'd2) |-> acc_fault);

  // R8
  user_background_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && chk_on && !hit_valid && !acc_priv) |-> acc_fault);

  // R8
  priv_background_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_on && !hit_valid && acc_priv) |-> acc_allow);

  // R11
  fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_fault) |=> flt_pulse);

  // R11
  fault_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_fault) |=> (flt_addr == $past(acc_addr)));

  // R11
  pulse_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && acc_fault) |=> !flt_pulse);

endmodule

bind region_guard rg_checker u_chk (
  .clk(clk), .rst(rst), .chk_on(chk_on), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
  .acc_allow(acc_allow), .acc_fault(acc_fault), .hit_valid(hit_valid),
  .hit_xn(hit_xn), .flt_pulse(flt_pulse), .flt_addr(flt_addr)
);

// File: tb/region_guard_bench.sv
module region_guard_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = 2'd0;
  logic        acc_priv = 1'b0;
  logic        acc_allow, acc_fault, hit_valid, hit_xn;
  logic [2:0]  hit_region;
  logic [5:0]  hit_mattr;
  logic        flt_pulse, flt_priv;
  logic [31:0] flt_addr;
  logic [1:0]  flt_kind;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  region_guard u_region_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
    .acc_allow(acc_allow), .acc_fault(acc_fault), .hit_valid(hit_valid),
    .hit_region(hit_region), .hit_mattr(hit_mattr), .hit_xn(hit_xn),
    .flt_pulse(flt_pulse), .flt_addr(flt_addr), .flt_kind(flt_kind),
    .flt_priv(flt_priv)
  );

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic en, input logic [4:0] code,
      input logic [7:0] srd, input logic [3:0] perm, input logic xn,
      input logic [5:0] mattr);
    return {3'b0, xn, perm, 2'b0, mattr, srd, 2'b0, code, en};
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = s;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic prog(input int idx, input logic [31:0] b, input logic [31:0] a);
    wr(3'd1, 32'(idx));
    wr(3'd2, b);
    wr(3'd3, a);
  endtask

  task automatic probe(input logic [31:0] a, input logic [1:0] k, input logic p);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p;
    #2;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 ctrl after reset", d, 32'h0);
    rd(3'd4, d); check("R1 type word", d, 32'h0000_0801);
    probe(32'h1234_5678, WR, 1'b0);
    check("R2 allow after reset", {31'b0, acc_allow}, 32'd1);
  endtask

  task automatic t_disabled();
    prog(0, 32'h0000_1000, mk(1, 5'd11, 8'h00, 4'h0, 0, 6'h0));
    probe(32'h0000_1010, WR, 1'b0);
    check("R2 region ignored while off", {30'b0, hit_valid, acc_allow}, 32'd1);
  endtask

  task automatic t_background();
    wr(3'd0, 32'h1);
    probe(32'h0000_1010, RD, 1'b0);
    check("R5 no-permission region faults user read", {31'b0, acc_fault}, 32'd1);
    probe(32'h7000_0000, RD, 1'b1);
    check("R8 privileged background allowed", {30'b0, hit_valid, acc_allow}, 32'd1);
    probe(32'h7000_0000, RD, 1'b0);
    check("R8 user background faults", {31'b0, acc_fault}, 32'd1);
  endtask

  task automatic t_size_align();
    logic [31:0] d;
    prog(1, 32'h2000_0123, mk(1, 5'd9, 8'h00, 4'hF, 0, 6'h0));
    rd(3'd2, d); check("R1 base readback low bits dropped", d, 32'h2000_0100);
    rd(3'd3, d); check("R1 attr readback", d, mk(1, 5'd9, 8'h00, 4'hF, 0, 6'h0));
    probe(32'h2000_03FC, RD, 1'b0);
    check("R3 last word of 1KB region", {28'b0, hit_region, acc_allow}, 32'h3);
    probe(32'h2000_0400, RD, 1'b0);
    check("R3 first byte past region", {30'b0, hit_valid, acc_fault}, 32'd1);
  endtask

  task automatic t_subregion();
    prog(1, 32'h2000_0000, mk(1, 5'd9, 8'h04, 4'hF, 0, 6'h0));
    probe(32'h2000_0100, RD, 1'b0);
    check("R4 disabled subregion 2 falls through", {30'b0, hit_valid, acc_fault}, 32'd1);
    probe(32'h2000_0080, RD, 1'b0);
    check("R4 neighbour subregion 1 still open", {30'b0, hit_valid, acc_allow}, 32'd3);
  endtask

  task automatic t_perm();
    prog(2, 32'h3000_0000, mk(1, 5'd11, 8'h00, 4'h1, 0, 6'h0));
    probe(32'h3000_0010, RD, 1'b1);
    check("R5 priv read allowed", {31'b0, acc_allow}, 32'd1);
    probe(32'h3000_0010, WR, 1'b1);
    check("R5 priv write refused", {31'b0, acc_fault}, 32'd1);
    probe(32'h3000_0010, RD, 1'b0);
    check("R5 user read refused", {31'b0, acc_fault}, 32'd1);
    probe(32'h3000_0010, FE, 1'b1);
    check("R5 priv fetch uses read bit", {31'b0, acc_allow}, 32'd1);
  endtask

  task automatic t_xn();
    prog(3, 32'h4000_0000, mk(1, 5'd15, 8'h00, 4'hF, 1, 6'h2D));
    probe(32'h4000_1000, RD, 1'b0);
    check("R6 read in xn region allowed", {28'b0, hit_region, acc_allow}, 32'h7);
    check("R9 memory attributes reported", {26'b0, hit_mattr}, 32'h2D);
    probe(32'h4000_1000, FE, 1'b0);
    check("R6 user fetch faults", {30'b0, hit_xn, acc_fault}, 32'd3);
    probe(32'h4000_1000, FE, 1'b1);
    check("R6 priv fetch faults", {31'b0, acc_fault}, 32'd1);
  endtask

  task automatic t_overlap();
    prog(4, 32'h4000_0000, mk(1, 5'd11, 8'h00, 4'h0, 0, 6'h00));
    probe(32'h4000_0010, RD, 1'b0);
    check("R7 higher region wins", {28'b0, hit_region, acc_fault}, 32'h9);
    probe(32'h4000_0010, RD, 1'b1);
    check("R7 higher region wins priv", {31'b0, acc_fault}, 32'd1);
    probe(32'h4000_1000, RD, 1'b0);
    check("R7 outside small region lower one decides", {28'b0, hit_region, acc_allow}, 32'h7);
  endtask

  task automatic t_zeroed();
    prog(4, 32'h0, 32'h0);
    probe(32'h4000_0010, RD, 1'b0);
    check("R10 zeroed region gone", {28'b0, hit_region, acc_allow}, 32'h7);
  endtask

  task automatic t_fault_log();
    probe(32'h3000_0004, WR, 1'b0);
    check("R11 fault raised", {31'b0, acc_fault}, 32'd1);
    @(negedge clk);
    check("R11 pulse next cycle", {31'b0, flt_pulse}, 32'd1);
    check("R11 captured address", flt_addr, 32'h3000_0004);
    check("R11 captured kind and priv", {29'b0, flt_kind, flt_priv}, 32'h2);
    acc_valid = 1'b0;
    @(negedge clk);
    check("R11 pulse drops", {31'b0, flt_pulse}, 32'd0);
    wr(3'd0, 32'h0);
    probe(32'h3000_0004, WR, 1'b0);
    check("R2 off again allows", {31'b0, acc_allow}, 32'd1);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_background();
    t_size_align();
    t_subregion();
    t_perm();
    t_xn();
    t_overlap();
    t_zeroed();
    t_fault_log();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule